// File: doc/BRIEF.md
# Dual-Latency Execute Dispatcher

This block controls issue into an execute stage built from two functional units that are not pipelined. The quick unit holds an instruction for two cycles and the slow unit holds one for four cycles. Every instruction arriving from decode names exactly one of the two units. An instruction is accepted only when the unit it names is free. While it waits, the block raises a stall so that decode keeps the instruction and fetch keeps the one behind it. Nothing is buffered in front of the units.

Each unit counts down its own occupancy and offers its result to a single writeback port when the count ends. A quick instruction issued after a slow one can therefore retire first. If both units finish in the same cycle, the older instruction takes writeback. The younger one keeps its unit occupied for one more cycle and retires in the next cycle. The computation is modelled as the instruction tag passing through, so each retirement can be matched against the issue order.

Top module: `exu_dispatch`

## Requirements
- R1: After reset, `wbValid` is 0 and `issueStall` is 0, and `wbValid` stays 0 until an instruction has been accepted.
- R2: An instruction accepted into the quick unit (`issueUnit`=0) at the clock edge that ends cycle c appears on writeback in cycle c+2, with `wbUnit`=0, unless a same-cycle conflict holds it back (R7).
- R3: An instruction accepted into the slow unit (`issueUnit`=1) at the edge that ends cycle c appears on writeback in cycle c+4, with `wbUnit`=1, unless R7 holds it back.
- R4: `issueStall` is 1 exactly when `issueValid` is 1 and the selected unit is still occupied. A stalled request is held at the inputs and is accepted at the first edge where its unit is free.
- R5: A unit that retires its instruction in a cycle can accept a new instruction at the edge that ends that same cycle, with no bubble.
- R6: Retirement follows unit latency, not issue order. For the quick, slow, quick, slow, quick sequence, instruction 3 retires before 2 and instruction 5 retires before 4.
- R7: When both units finish in the same cycle, the instruction that was issued earlier retires in that cycle. The other retires in the next cycle, and its unit stalls new requests during the extra cycle.
- R8: An occupied unit never stalls a request that names the other unit when that unit is free.
- R9: `wbTag` equals the `issueTag` that was captured when the retiring instruction was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Decode presents an instruction |
| issueUnit | input | 1 | Target unit: 0 quick, 1 slow |
| issueTag | input | TAG_W | Instruction tag carried to writeback |
| issueStall | output | 1 | Hold decode and fetch this cycle |
| wbValid | output | 1 | A result is on the writeback port |
| wbUnit | output | 1 | Unit that produced the result |
| wbTag | output | TAG_W | Tag of the retiring instruction |

## Verification
The assertions assume that the front end holds `issueValid`, `issueUnit` and `issueTag` steady while `issueStall` is high. The bench driver respects this by keeping each request on the inputs until it samples a cycle without a stall. The assertions also assume that the writeback port never refuses a result. The block has no back-pressure input, so the bench follows that by design. Requests are changed only on the falling edge, so the combinational stall settles before the next accepting edge.

// File: rtl/exu_dispatch_pkg.sv
package exu_dispatch_pkg;

  localparam int NUM_UNITS = 2;

  typedef enum logic {
    UNIT_QUICK = 1'b0,
    UNIT_SLOW  = 1'b1
  } unitSel_t;

  // strobes from issue control to the occupancy datapath
  typedef struct packed {
    logic [NUM_UNITS-1:0] load;   // capture a new instruction into the unit
    logic [NUM_UNITS-1:0] grant;  // unit owns writeback this cycle
  } unitStrobes_t;

endpackage

// File: rtl/exu_occupancy.sv
module exu_occupancy
  import exu_dispatch_pkg::*;
#(
  parameter int TAG_W     = 8,
  parameter int LAT_QUICK = 2,
  parameter int LAT_SLOW  = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  unitStrobes_t                    strobes,
  input  logic [TAG_W-1:0]                issueTag,
  output logic [NUM_UNITS-1:0]            unitBusy,
  output logic [NUM_UNITS-1:0]            unitReady,
  output logic [NUM_UNITS-1:0][TAG_W-1:0] unitTag
);

  localparam int LAT_MAX = (LAT_QUICK > LAT_SLOW) ? LAT_QUICK : LAT_SLOW;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    localparam int LAT = (u == 0) ? LAT_QUICK : LAT_SLOW;

    logic [CNT_W-1:0] remainQ;
    logic [TAG_W-1:0] tagQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        remainQ <= '0;
        tagQ    <= '0;
      end else if (strobes.load[u]) begin
        remainQ <= CNT_W'(LAT);
        tagQ    <= issueTag;
      end else if (strobes.grant[u]) begin
        remainQ <= '0;
      end else if (remainQ > CNT_W'(1)) begin
        remainQ <= remainQ - 1'b1;
      end
    end

    assign unitBusy[u]  = (remainQ != '0);
    assign unitReady[u] = (remainQ == CNT_W'(1));
    assign unitTag[u]   = tagQ;

    // R4: a unit is refilled only when empty or retiring in this very cycle
    assert_load_when_free_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobes.load[u] |-> (!unitBusy[u] || strobes.grant[u]));

    // R7: a finished result that lost writeback waits, unchanged
    assert_held_result_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
      (unitReady[u] && !strobes.grant[u] && !strobes.load[u]) |=> (unitReady[u] && $stable(tagQ)));

    // R9: writeback is granted only to a unit holding a finished result
    assert_grant_needs_result_R9: assert property (@(posedge clk) disable iff (!rstN)
      strobes.grant[u] |-> unitReady[u]);
  end

endmodule

// File: rtl/exu_issue_ctrl.sv
module exu_issue_ctrl
  import exu_dispatch_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 issueValid,
  input  logic                 issueUnit,
  input  logic [NUM_UNITS-1:0] unitBusy,
  input  logic [NUM_UNITS-1:0] unitReady,
  output unitStrobes_t         strobes,
  output logic                 issueStall,
  output logic                 wbValid,
  output logic                 wbUnit
);

  logic                 lastUnitQ;  // unit that took the most recent instruction
  logic                 olderUnit;
  logic [NUM_UNITS-1:0] grant;
  logic [NUM_UNITS-1:0] unitFree;
  logic [NUM_UNITS-1:0] load;

  // both units finished means both hold work; the later issue is in lastUnitQ
  assign olderUnit = ~lastUnitQ;

  always_comb begin
    grant = '0;
    if (&unitReady) grant[olderUnit] = 1'b1;
    else            grant = unitReady;
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      unitFree[u] = !unitBusy[u] || grant[u];
      load[u]     = issueValid && (issueUnit == u[0]) && unitFree[u];
    end
  end

  assign issueStall    = issueValid && !unitFree[issueUnit];
  assign strobes.load  = load;
  assign strobes.grant = grant;
  assign wbValid       = |grant;
  assign wbUnit        = grant[UNIT_SLOW];

  always_ff @(posedge clk) begin
    if (!rstN)           lastUnitQ <= UNIT_QUICK;
    else if (|load)      lastUnitQ <= issueUnit;
  end

  // R7: the single writeback port serves one unit per cycle
  assert_one_writeback_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  // R7: a double finish is followed by the deferred retirement
  assert_deferred_retire_R7: assert property (@(posedge clk) disable iff (!rstN)
    (&unitReady) |=> wbValid);

  // R4: no stall without a request
  assert_stall_needs_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    issueStall |-> issueValid);

  // R4: a stall accepts nothing
  assert_stall_blocks_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    issueStall |-> !(|load));

endmodule

// File: rtl/exu_dispatch.sv
module exu_dispatch
  import exu_dispatch_pkg::*;
#(
  parameter int TAG_W     = 8,
  parameter int LAT_QUICK = 2,
  parameter int LAT_SLOW  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             issueUnit,
  input  logic [TAG_W-1:0] issueTag,
  output logic             issueStall,
  output logic             wbValid,
  output logic             wbUnit,
  output logic [TAG_W-1:0] wbTag
);

  unitStrobes_t                    strobes;
  logic [NUM_UNITS-1:0]            unitBusy;
  logic [NUM_UNITS-1:0]            unitReady;
  logic [NUM_UNITS-1:0][TAG_W-1:0] unitTag;

  exu_issue_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .issueUnit  (issueUnit),
    .unitBusy   (unitBusy),
    .unitReady  (unitReady),
    .strobes    (strobes),
    .issueStall (issueStall),
    .wbValid    (wbValid),
    .wbUnit     (wbUnit)
  );

  exu_occupancy #(
    .TAG_W     (TAG_W),
    .LAT_QUICK (LAT_QUICK),
    .LAT_SLOW  (LAT_SLOW)
  ) u_occ (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .issueTag  (issueTag),
    .unitBusy  (unitBusy),
    .unitReady (unitReady),
    .unitTag   (unitTag)
  );

  assign wbTag = unitTag[wbUnit];

  // R8: a free unit is never blocked by the other unit's occupancy
  assert_no_cross_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !unitBusy[issueUnit]) |-> !issueStall);

  // R1: nothing retires in the first cycle after reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !wbValid);

endmodule

// File: tb/exu_dispatch_bench.sv
`timescale 1ns/1ps
module exu_dispatch_bench;

  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       issueValid = 1'b0;
  logic       issueUnit = 1'b0;
  logic [7:0] issueTag = '0;
  logic       issueStall, wbValid, wbUnit;
  logic [7:0] wbTag;

  int cyc = 0;
  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  typedef struct { logic unit; logic [7:0] tag; int at; } expItem_t;
  expItem_t expQ[$];

  always #(HALF) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  exu_dispatch u_exu_dispatch (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueUnit(issueUnit),
    .issueTag(issueTag), .issueStall(issueStall), .wbValid(wbValid),
    .wbUnit(wbUnit), .wbTag(wbTag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic pushExp(input logic u, input logic [7:0] t, input int at);
    expItem_t e;
    e.unit = u; e.tag = t; e.at = at;
    expQ.push_back(e);
  endtask

  // driver: called on a falling edge, holds the request until accepted
  task automatic sendOp(input logic u, input logic [7:0] t, input int expAcc, input string req);
    issueValid = 1'b1; issueUnit = u; issueTag = t;
    forever begin
      #1;
      if (!issueStall) break;
      @(negedge clk);
    end
    check(cyc == expAcc, req, cyc, expAcc);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  // monitor: compares every retirement against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && wbValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R1 R6 spurious writeback tag", int'(wbTag), -1);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(cyc == e.at, "R2 R3 R7 retire cycle", cyc, e.at);
          check(wbUnit == e.unit, "R2 R3 R6 retire unit", int'(wbUnit), int'(e.unit));
          check(wbTag == e.tag, "R9 retire tag", int'(wbTag), int'(e.tag));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int b;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(wbValid == 1'b0, "R1 wbValid after reset", int'(wbValid), 0);
    check(issueStall == 1'b0, "R1 issueStall after reset", int'(issueStall), 0);
    @(negedge clk);

    // R6 R8 R5 R4: quick, slow, quick, slow, quick back to back
    b = cyc;
    pushExp(1'b0, 8'h11, b + 2);
    pushExp(1'b0, 8'h13, b + 4);
    pushExp(1'b1, 8'h12, b + 5);
    pushExp(1'b0, 8'h15, b + 8);
    pushExp(1'b1, 8'h14, b + 9);
    sendOp(1'b0, 8'h11, b,     "R2 accept op1");
    sendOp(1'b1, 8'h12, b + 1, "R8 accept op2");
    sendOp(1'b0, 8'h13, b + 2, "R5 accept op3");
    sendOp(1'b1, 8'h14, b + 5, "R4 stalled op4");
    sendOp(1'b0, 8'h15, b + 6, "R6 accept op5");
    repeat (6) @(negedge clk);

    // R7: both units finish together, then the held unit stalls a newcomer
    b = cyc;
    pushExp(1'b1, 8'hA0, b + 4);
    pushExp(1'b0, 8'hB0, b + 5);
    pushExp(1'b0, 8'hC0, b + 7);
    sendOp(1'b1, 8'hA0, b, "R3 accept slow");
    @(negedge clk);
    sendOp(1'b0, 8'hB0, b + 2, "R8 accept quick");
    sendOp(1'b0, 8'hC0, b + 5, "R7 held unit stall");
    repeat (6) @(negedge clk);

    // R5 R3: back-to-back slow ops reuse the unit in its retire cycle
    b = cyc;
    pushExp(1'b1, 8'h5D, b + 4);
    pushExp(1'b1, 8'h5E, b + 8);
    sendOp(1'b1, 8'h5D, b,     "R3 accept slow first");
    sendOp(1'b1, 8'h5E, b + 4, "R5 same-cycle reuse");
    repeat (8) @(negedge clk);

    check(expQ.size() == 0, "R6 all retirements seen", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule